// File: doc/BRIEF.md
# Status Register with Write Latches

This block is the status and write-protect byte of a timekeeping device. Two volatile enable latches guard stores. The first guards the general memory array. Both together guard the clock and control registers. The same byte also reports a backup-supply flag, a clock-lost flag and two alarm flags. The alarm flags clear when a status read completes, but only for the alarms already set when that read began.

A host reaches the block through a plain register bus: an address, a write strobe with data, a read strobe, and a read-done pulse that marks the end of a read transfer. Every store returns an acceptance pulse that takes the place of a bus acknowledge. This pulse is how a host learns that a guarded store was refused. The bus never back-pressures: every strobe is taken in the cycle it is presented, so there is no ready signal and no handshake. Hardware drives the alarm-match pulses, the battery-mode level and the power-loss pulse.

Top module: `stat_latch_reg`

## Requirements
- R1: After reset, a status read (address 3Fh) returns 01h: only the clock-lost flag (bit 0) is set, and `wr_ack` is low.
- R2: Bits 4 and 3 of the status byte always read 0, even after stores such as 1Ah or FFh to the status address. Such stores leave every other bit unchanged.
- R3: The array-enable latch (bit 1) is set only by storing exactly 02h at the status address. Other values with bit 1 set, such as 03h or 12h, leave it unchanged.
- R4: Storing 00h at the status address clears both enable latches (bits 1 and 2).
- R5: Storing 06h at the status address sets the register-enable latch (bit 2) only when the array-enable latch is already 1. While the array-enable latch is 0, storing 06h has no effect.
- R6: Stores to the status address are always accepted. Stores to control addresses 30h through 37h are accepted only when both latches are 1. Stores to any other address are accepted only when the array-enable latch is 1. `wr_ack` pulses high for one cycle, one cycle after an accepted store.
- R7: The clock-lost flag (bit 0) is 1 after reset and after a `pwr_lost` pulse. It is cleared by the first accepted store to a control address. A refused control store leaves it set.
- R8: Bit 7 of a status read reports the level of `bat_mode` in the cycle of the read strobe.
- R9: A pulse on `alarm_hit[0]` sets bit 5 and a pulse on `alarm_hit[1]` sets bit 6. A set flag stays set until a status read completes.
- R10: On `rd_done`, only the alarm flags captured at the read strobe are cleared. An alarm that arrives after the strobe, or in the same cycle as `rd_done`, remains set.
- R11: A store to the status address never changes bits 7, 6, 5 or 0.
- R12: `rd_data` holds the addressed value one cycle after `rd_en`. A read of any address other than 3Fh returns 00h and captures no alarm flags, so a following `rd_done` clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, standing for power-up after total power loss |
| addr | input | 8 | Register address for a read or a store |
| wr_en | input | 1 | Store strobe, one cycle |
| wr_data | input | 8 | Store data |
| rd_en | input | 1 | Read strobe, one cycle |
| rd_done | input | 1 | End-of-read pulse |
| rd_data | output | 8 | Read data, registered |
| wr_ack | output | 1 | Store accepted, one cycle after the strobe |
| alarm_hit | input | 2 | Alarm-match pulses, bit 0 for alarm 0 and bit 1 for alarm 1 |
| bat_mode | input | 1 | High while running from the backup supply |
| pwr_lost | input | 1 | Pulse reporting a total power loss |

## Verification
`rd_data` and `wr_ack` are both due exactly one clock edge after their strobe. Latch changes, flag sets and flag clears become visible in the next status read. The bench's driver presents every strobe on a falling edge and queues the value it predicts. A monitor notes which strobes were seen at the rising edge and compares each result at the falling edge that follows, so every comparison falls half a cycle after the update is due. Alarm pulses in the window between a read strobe and its `rd_done`, and pulses that coincide with `rd_done`, are placed on chosen cycles so the preservation rule is checked at its edges.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned NUM_ALM  = 2;
  localparam int unsigned POS_BAT  = 7;
  localparam int unsigned POS_ALM  = 5;   // alarm n sits at POS_ALM + n
  localparam int unsigned POS_RWEN = 2;
  localparam int unsigned POS_AWEN = 1;
  localparam int unsigned POS_LOST = 0;

  localparam logic [DATA_W-1:0] CODE_ARM_ARRAY = 8'h02;
  localparam logic [DATA_W-1:0] CODE_ARM_REGS  = 8'h06;
  localparam logic [DATA_W-1:0] CODE_DISARM    = 8'h00;

  typedef enum logic [1:0] {
    TGT_ARRAY  = 2'd0,
    TGT_CTRL   = 2'd1,
    TGT_STATUS = 2'd2
  } tgt_e;
endpackage

// File: rtl/stat_addr_dec.sv
module stat_addr_dec
  import stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h3F,
  parameter logic [ADDR_W-1:0] CTRL_LO = 'h30,
  parameter logic [ADDR_W-1:0] CTRL_HI = 'h37
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt
);
  always_comb begin
    if (addr == STAT_ADDR)                       tgt = TGT_STATUS;
    else if (addr >= CTRL_LO && addr <= CTRL_HI) tgt = TGT_CTRL;
    else                                         tgt = TGT_ARRAY;
  end
endmodule

// File: rtl/stat_wr_latch.sv
module stat_wr_latch
  import stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stat,
  input  logic [DATA_W-1:0] wr_data,
  output logic              awen,
  output logic              rwen
);
  always_ff @(posedge clk) begin
    if (rst) begin
      awen <= 1'b0;
      rwen <= 1'b0;
    end else if (wr_stat) begin
      case (wr_data)
        CODE_ARM_ARRAY: awen <= 1'b1;
        CODE_ARM_REGS:  if (awen) rwen <= 1'b1;
        CODE_DISARM: begin
          awen <= 1'b0;
          rwen <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R5
  rwen_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rwen) |-> $past(awen));

  // R3
  awen_code_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(awen) |-> $past(wr_stat && wr_data == CODE_ARM_ARRAY));
endmodule

// File: rtl/stat_alarm_flags.sv
module stat_alarm_flags
  import stat_pkg::*;
#(
  parameter int unsigned N = NUM_ALM
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] alarm_in,
  input  logic         snap_take,
  input  logic         snap_clear,
  output logic [N-1:0] flags
);
  logic [N-1:0] snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      snap  <= '0;
    end else begin
      if (snap_clear) flags <= (flags & ~snap) | alarm_in;
      else            flags <= flags | alarm_in;
      if (snap_take)       snap <= flags;
      else if (snap_clear) snap <= '0;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_chk
    // R9
    alarm_set_chk: assert property (@(posedge clk) disable iff (rst)
      $past(alarm_in[g]) |-> flags[g]);

    // R10
    late_alarm_kept_chk: assert property (@(posedge clk) disable iff (rst)
      (snap_clear && !snap[g] && flags[g]) |=> flags[g]);
  end
endmodule

// File: rtl/stat_latch_reg.sv
module stat_latch_reg
  import stat_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 'h3F,
  parameter logic [ADDR_W-1:0] CTRL_LO = 'h30,
  parameter logic [ADDR_W-1:0] CTRL_HI = 'h37
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rd_en,
  input  logic                 rd_done,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 wr_ack,
  input  logic [NUM_ALM-1:0]   alarm_hit,
  input  logic                 bat_mode,
  input  logic                 pwr_lost
);
  tgt_e                tgt;
  logic                awen, rwen, lost;
  logic                wr_ok, ctrl_ok;
  logic [NUM_ALM-1:0]  alm;
  logic [DATA_W-1:0]   stat_byte;

  stat_addr_dec #(
    .ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .CTRL_LO(CTRL_LO), .CTRL_HI(CTRL_HI)
  ) i_dec (
    .addr(addr),
    .tgt (tgt)
  );

  stat_wr_latch i_latch (
    .clk    (clk),
    .rst    (rst),
    .wr_stat(wr_en && tgt == TGT_STATUS),
    .wr_data(wr_data),
    .awen   (awen),
    .rwen   (rwen)
  );

  stat_alarm_flags #(.N(NUM_ALM)) i_alarm (
    .clk       (clk),
    .rst       (rst),
    .alarm_in  (alarm_hit),
    .snap_take (rd_en && tgt == TGT_STATUS),
    .snap_clear(rd_done),
    .flags     (alm)
  );

  always_comb begin
    ctrl_ok = wr_en && tgt == TGT_CTRL && awen && rwen;
    wr_ok   = ctrl_ok
            || (wr_en && tgt == TGT_STATUS)
            || (wr_en && tgt == TGT_ARRAY && awen);
  end

  always_comb begin
    stat_byte = '0;
    stat_byte[POS_BAT] = bat_mode;
    stat_byte[POS_ALM +: NUM_ALM] = alm;
    stat_byte[POS_RWEN] = rwen;
    stat_byte[POS_AWEN] = awen;
    stat_byte[POS_LOST] = lost;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lost    <= 1'b1;
      wr_ack  <= 1'b0;
      rd_data <= '0;
    end else begin
      if (pwr_lost)     lost <= 1'b1;
      else if (ctrl_ok) lost <= 1'b0;
      wr_ack <= wr_ok;
      if (rd_en) rd_data <= (tgt == TGT_STATUS) ? stat_byte : '0;
    end
  end

  // R6
  ack_follows_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ack |-> $past(wr_en));

  // R7
  lost_clear_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(lost) |-> wr_ack);
endmodule

// File: tb/test_stat_latch_reg.sv
`timescale 1ns/1ps
module test_stat_latch_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic       rd_done = 1'b0;
  logic [7:0] rd_data;
  logic       wr_ack;
  logic [1:0] alarm_hit = '0;
  logic       bat_mode = 1'b0;
  logic       pwr_lost = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t rdq[$];
  item_t wrq[$];
  logic  pend_rd = 1'b0;
  logic  pend_wr = 1'b0;

  always #2 clk = ~clk;

  stat_latch_reg i_stat_latch_reg (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_done(rd_done), .rd_data(rd_data), .wr_ack(wr_ack),
    .alarm_hit(alarm_hit), .bat_mode(bat_mode), .pwr_lost(pwr_lost)
  );

  function automatic void compare(logic [7:0] act, logic [7:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endfunction

  // monitor: note strobes at the rising edge, compare at the falling edge
  always @(posedge clk) begin
    pend_rd <= rd_en && !rst;
    pend_wr <= wr_en && !rst;
  end

  always @(negedge clk) begin
    if (pend_rd) begin
      item_t it;
      it = rdq.pop_front();
      compare(rd_data, it.exp, it.tag);
    end
    if (pend_wr) begin
      item_t it;
      it = wrq.pop_front();
      compare({7'b0, wr_ack}, it.exp, it.tag);
    end
  end

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    rdq.push_back('{exp, tag});
    @(negedge clk);
    rd_en = 1'b0; rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic ack,
                    input string tag);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    wrq.push_back('{{7'b0, ack}, tag});
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_alarm(input logic [1:0] v);
    @(negedge clk);
    alarm_hit = v;
    @(negedge clk);
    alarm_hit = '0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    compare({7'b0, wr_ack}, 8'h00, "R1 ack low after reset");
    rd(8'h3F, 8'h01, "R1 reset value");

    wr(8'h30, 8'hAA, 1'b0, "R6 ctrl refused, no latches");
    rd(8'h3F, 8'h01, "R7 lost flag kept after refused store");
    wr(8'h10, 8'h55, 1'b0, "R6 array refused");
    wr(8'h3F, 8'h06, 1'b1, "R6 status store accepted");
    rd(8'h3F, 8'h01, "R5 06h ignored without array latch");
    wr(8'h3F, 8'h03, 1'b1, "R6 status store accepted");
    rd(8'h3F, 8'h01, "R3 03h does not arm");
    wr(8'h3F, 8'h12, 1'b1, "R6 status store accepted");
    rd(8'h3F, 8'h01, "R3 12h does not arm");
    wr(8'h3F, 8'h02, 1'b1, "R6 status store accepted");
    rd(8'h3F, 8'h03, "R3 02h arms array latch");
    wr(8'h10, 8'h55, 1'b1, "R6 array accepted");
    wr(8'h31, 8'h55, 1'b0, "R6 ctrl refused with array latch only");
    rd(8'h3F, 8'h03, "R7 lost flag kept");
    wr(8'h3F, 8'h1A, 1'b1, "R6 status store accepted");
    rd(8'h3F, 8'h03, "R2 1Ah leaves byte");
    wr(8'h3F, 8'hFF, 1'b1, "R6 status store accepted");
    rd(8'h3F, 8'h03, "R2 R11 FFh leaves byte");
    wr(8'h3F, 8'h06, 1'b1, "R6 status store accepted");
    rd(8'h3F, 8'h07, "R5 06h arms register latch");
    wr(8'h37, 8'h11, 1'b1, "R6 ctrl accepted at top of range");
    rd(8'h3F, 8'h06, "R7 lost flag cleared");
    wr(8'h3F, 8'h00, 1'b1, "R6 status store accepted");
    rd(8'h3F, 8'h00, "R4 00h clears both latches");
    wr(8'h33, 8'h11, 1'b0, "R6 ctrl refused after disarm");

    @(negedge clk); pwr_lost = 1'b1;
    @(negedge clk); pwr_lost = 1'b0;
    rd(8'h3F, 8'h01, "R7 power loss sets flag");

    bat_mode = 1'b1;
    rd(8'h3F, 8'h81, "R8 battery bit");
    bat_mode = 1'b0;
    rd(8'h3F, 8'h01, "R8 battery bit follows level");

    pulse_alarm(2'b01);
    rd(8'h3F, 8'h21, "R9 alarm 0 flag");
    rd(8'h3F, 8'h01, "R10 alarm 0 cleared after read");

    // alarm 0 arrives between strobe and done
    pulse_alarm(2'b10);
    @(negedge clk);
    addr = 8'h3F; rd_en = 1'b1;
    rdq.push_back('{8'h41, "R9 alarm 1 flag"});
    @(negedge clk);
    rd_en = 1'b0; alarm_hit = 2'b01;
    @(negedge clk);
    alarm_hit = '0; rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
    rd(8'h3F, 8'h21, "R10 alarm during read kept");
    rd(8'h3F, 8'h01, "R10 kept alarm cleared by next read");

    // alarm 1 repeats in the cycle of rd_done
    pulse_alarm(2'b10);
    @(negedge clk);
    addr = 8'h3F; rd_en = 1'b1;
    rdq.push_back('{8'h41, "R9 alarm 1 flag"});
    @(negedge clk);
    rd_en = 1'b0; rd_done = 1'b1; alarm_hit = 2'b10;
    @(negedge clk);
    rd_done = 1'b0; alarm_hit = '0;
    rd(8'h3F, 8'h41, "R10 alarm with done kept");
    rd(8'h3F, 8'h01, "R10 cleared afterwards");

    pulse_alarm(2'b01);
    wr(8'h3F, 8'h00, 1'b1, "R6 status store accepted");
    rd(8'h3F, 8'h21, "R11 status store keeps flags");

    pulse_alarm(2'b10);
    rd(8'h10, 8'h00, "R12 other address reads zero");
    rd(8'h3F, 8'h41, "R12 other read clears nothing");
    rd(8'h3F, 8'h01, "R12 status read clears");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule